// File: doc/BRIEF.md
# MESI Line-State Controller for a Snooping Bus

This block keeps the four-state coherence status (Modified, Exclusive, Shared, Invalid) for every line of one small private cache that shares a snooping bus with other caches. A core presents one local request at a time: a read, a write, a voluntary clean (write a dirty line back but keep it), or a drop (give the line up). For every request the block tells the core, in the same cycle, whether it completes locally, needs a bus transaction, or is held back by snoop activity. When a bus transaction is needed, the block issues it, waits for the memory side to finish it, updates the line and then evaluates the request again.

On the other side it watches transactions from other caches. These are a read, a read-for-ownership, an invalidate (upgrade) and a writeback. It answers at once with two flags. One says the line is held clean here. The other tells the remote requester to retry, because a dirty copy lives here. In that case the block writes the dirty line back on its own, and the snoop's transaction takes priority over local work. Data storage, replacement choice and memory are outside the block. The line address selects one of the tracked lines directly.

The outgoing bus transaction is a valid/ready stream. Once `bo_valid` is raised, `bo_cmd` and `bo_line` hold still until a cycle in which `bo_ready` is high. At most one transaction is outstanding. It ends with a one-cycle `bus_done`, which carries `bus_shared`, or with a one-cycle `bus_retry`, after which the transaction is issued again. The local request is also valid/ready: `lreq_ready` rises in the cycle the request completes, and the request must stay unchanged until then.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 2'b00; Shared 2'b01, Exclusive 2'b10, Modified 2'b11), `bo_valid`, `lreq_ready` and `snp_retry` are low, and a first read of any line reports a bus need (outcome 2'b01).
- R2: A read (op 2'b00) of a line in any valid state completes in the same cycle, with outcome 2'b00 and no bus transaction.
- R3: A read of an Invalid line issues a bus read (cmd 2'b00). On `bus_done` the line becomes Shared if `bus_shared` was high, else Exclusive.
- R4: A write (op 2'b01) to an Exclusive or Modified line completes locally in the same cycle, and the line ends up Modified with no bus transaction.
- R5: A write to a Shared line issues an invalidate (cmd 2'b10), and a write to an Invalid line issues a read-for-ownership (cmd 2'b01). Either one leaves the line Modified, and the write then completes.
- R6: A snooped read (cmd 2'b00) or read-for-ownership (cmd 2'b01) that hits a Modified line raises `snp_retry` in the same cycle. The block then issues a writeback (cmd 2'b11) of that line ahead of any local transaction. On completion the line becomes Shared after a snooped read, or Invalid after a snooped read-for-ownership.
- R7: A snooped read that hits an Exclusive or Shared line raises `snp_shared` and leaves the line Shared. A snooped read-for-ownership or invalidate that hits a clean line makes it Invalid.
- R8: A clean (op 2'b10) of a Modified line issues a writeback and leaves the line Exclusive. A clean of any other line completes locally.
- R9: A drop (op 2'b11) of a clean line makes it Invalid locally, with no bus transaction. A drop of a Modified line writes it back first.
- R10: A local request to the line of a snoop in the same cycle, or to a line with a snoop writeback pending, reports stall (outcome 2'b10) and does not complete. It is evaluated again in the next cycle.
- R11: `bo_valid`, `bo_cmd` and `bo_line` stay stable until `bo_ready`. A `bus_retry` makes the block issue the same transaction again.
- R12: A snooped writeback, or any snoop of an Invalid line, raises neither response flag and leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lreq_valid | input | 1 | Local request present |
| lreq_ready | output | 1 | Local request completes this cycle |
| lreq_op | input | 2 | 0 read, 1 write, 2 clean, 3 drop |
| lreq_line | input | LW | Line addressed by the local request |
| lreq_outcome | output | 2 | 0 completes locally, 1 needs/awaits bus, 2 stalled by snoop |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_cmd | input | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 writeback |
| snp_line | input | LW | Line of the snooped transaction |
| snp_retry | output | 1 | Remote requester must retry; dirty copy held here |
| snp_shared | output | 1 | A clean copy is held here |
| bo_valid | output | 1 | Outgoing bus transaction requested |
| bo_ready | input | 1 | Bus grant; transaction accepted when both are high |
| bo_cmd | output | 2 | Outgoing command, same encoding as snp_cmd |
| bo_line | output | LW | Line of the outgoing transaction |
| bus_done | input | 1 | One-cycle completion of the outstanding transaction |
| bus_shared | input | 1 | Another cache holds the line, valid with bus_done |
| bus_retry | input | 1 | One-cycle abort; the transaction must be reissued |

## Verification
The outcome, `lreq_ready`, `snp_retry` and `snp_shared` are combinational, so the bench checks them late in the same cycle the stimulus is driven. A bus transaction appears on `bo_valid` in the cycle after the request or snoop that caused it. The line's new state applies at the edge that sees `bus_done`, and the re-evaluated request completes one cycle after that. The bench therefore waits on `lreq_ready` within a bounded window rather than at a fixed offset. Every accepted bus transaction is compared, in order, against a queue of expected command and line pairs that the stimulus tasks fill. Each line's state is inferred only from what later requests and snoops report at the ports.

// File: rtl/mesi_lc_pkg.sv
package mesi_lc_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'b00,
    LS_S = 2'b01,
    LS_E = 2'b10,
    LS_M = 2'b11
  } lstate_e;

  // bus / snoop command codes
  localparam logic [1:0] BC_RD   = 2'd0;
  localparam logic [1:0] BC_RDX  = 2'd1;
  localparam logic [1:0] BC_UPGR = 2'd2;
  localparam logic [1:0] BC_WB   = 2'd3;

  // local operation codes
  localparam logic [1:0] OP_RD    = 2'd0;
  localparam logic [1:0] OP_WR    = 2'd1;
  localparam logic [1:0] OP_CLEAN = 2'd2;
  localparam logic [1:0] OP_DROP  = 2'd3;

  // local outcome codes
  localparam logic [1:0] OUT_HIT   = 2'd0;
  localparam logic [1:0] OUT_MISS  = 2'd1;
  localparam logic [1:0] OUT_STALL = 2'd2;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_e;

endpackage

// File: rtl/mesi_lc_store.sv
module mesi_lc_store
  import mesi_lc_pkg::*;
#(
  parameter int LINES = 4,
  localparam int LW = $clog2(LINES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  // bus completion update (highest priority)
  input  logic                   bus_en,
  input  logic [LW-1:0]          bus_line,
  input  logic [1:0]             bus_st,
  // snoop update
  input  logic                   snp_en,
  input  logic [LW-1:0]          snp_line,
  input  logic [1:0]             snp_st,
  // local update
  input  logic                   loc_en,
  input  logic [LW-1:0]          loc_line,
  input  logic [1:0]             loc_st,
  output logic [LINES-1:0][1:0]  st_q
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                st_q[g] <= LS_I;
      else if (bus_en && bus_line == LW'(g))     st_q[g] <= bus_st;
      else if (snp_en && snp_line == LW'(g))     st_q[g] <= snp_st;
      else if (loc_en && loc_line == LW'(g))     st_q[g] <= loc_st;
    end
  end

endmodule

// File: rtl/mesi_lc_snoop.sv
module mesi_lc_snoop
  import mesi_lc_pkg::*;
#(
  parameter int LINES = 4,
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [LW-1:0] snp_line,
  input  logic [1:0]    snp_st,
  input  logic          wb_clr,
  output logic          snp_retry,
  output logic          snp_shared,
  output logic          upd_en,
  output logic [1:0]    upd_st,
  output logic          pend,
  output logic [LW-1:0] pend_line,
  output logic          pend_inv
);

  logic is_rd, is_own, clean_hit, dirty_hit;

  always_comb begin
    is_rd     = snp_valid && snp_cmd == BC_RD;
    is_own    = snp_valid && (snp_cmd == BC_RDX || snp_cmd == BC_UPGR);
    clean_hit = snp_st == LS_S || snp_st == LS_E;
    dirty_hit = snp_valid && snp_st == LS_M &&
                (snp_cmd == BC_RD || snp_cmd == BC_RDX);

    snp_retry  = dirty_hit;
    snp_shared = is_rd && clean_hit;

    upd_en = 1'b0;
    upd_st = LS_I;
    if (is_rd && snp_st == LS_E) begin
      upd_en = 1'b1;
      upd_st = LS_S;
    end else if (is_own && clean_hit) begin
      upd_en = 1'b1;
      upd_st = LS_I;
    end
  end

  // one pending snoop writeback slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_line <= '0;
      pend_inv  <= 1'b0;
    end else if (dirty_hit && !pend) begin
      pend      <= 1'b1;
      pend_line <= snp_line;
      pend_inv  <= snp_cmd == BC_RDX;
    end else if (dirty_hit && snp_line == pend_line) begin
      pend_inv  <= pend_inv | (snp_cmd == BC_RDX);
    end else if (wb_clr) begin
      pend      <= 1'b0;
    end
  end

endmodule

// File: rtl/mesi_lc_busseq.sv
module mesi_lc_busseq
  import mesi_lc_pkg::*;
#(
  parameter int LINES = 4,
  localparam int LW = $clog2(LINES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pend,
  input  logic [LW-1:0]         pend_line,
  input  logic                  pend_inv,
  input  logic                  loc_go,
  input  logic [1:0]            loc_cmd,
  input  logic [LW-1:0]         loc_line,
  input  logic [LINES-1:0][1:0] st,
  input  logic                  bo_ready,
  input  logic                  bus_done,
  input  logic                  bus_shared,
  input  logic                  bus_retry,
  output logic                  bo_valid,
  output logic [1:0]            bo_cmd,
  output logic [LW-1:0]         bo_line,
  output logic                  busy,
  output logic [LW-1:0]         busy_line,
  output logic                  done_en,
  output logic [LW-1:0]         done_line,
  output logic [1:0]            done_st,
  output logic                  pend_clr
);

  seq_e          sq_q;
  logic [1:0]    cmd_q;
  logic [LW-1:0] line_q;
  logic          finish;
  logic          pend_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q   <= SQ_IDLE;
      cmd_q  <= BC_RD;
      line_q <= '0;
    end else begin
      unique case (sq_q)
        SQ_IDLE: begin
          if (pend) begin
            sq_q   <= SQ_REQ;
            cmd_q  <= BC_WB;
            line_q <= pend_line;
          end else if (loc_go) begin
            sq_q   <= SQ_REQ;
            cmd_q  <= loc_cmd;
            line_q <= loc_line;
          end
        end
        SQ_REQ:  if (bo_ready) sq_q <= SQ_WAIT;
        SQ_WAIT: if (bus_retry || bus_done) sq_q <= SQ_IDLE;
        default: sq_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    bo_valid   = sq_q == SQ_REQ;
    bo_cmd     = cmd_q;
    bo_line    = line_q;
    busy       = sq_q != SQ_IDLE;
    busy_line  = line_q;
    finish     = sq_q == SQ_WAIT && bus_done && !bus_retry;
    pend_match = pend && pend_line == line_q;

    done_line = line_q;
    done_en   = 1'b0;
    done_st   = LS_I;
    pend_clr  = 1'b0;
    if (finish) begin
      unique case (cmd_q)
        BC_RD: begin
          done_en = 1'b1;
          done_st = bus_shared ? LS_S : LS_E;
        end
        BC_RDX: begin
          done_en = 1'b1;
          done_st = LS_M;
        end
        BC_UPGR: begin
          // a snoop may have taken the copy while the upgrade waited
          done_en = st[line_q] == LS_S;
          done_st = LS_M;
        end
        default: begin
          done_en  = 1'b1;
          done_st  = pend_match ? (pend_inv ? LS_I : LS_S) : LS_E;
          pend_clr = pend_match;
        end
      endcase
    end
  end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_lc_pkg::*;
#(
  parameter int LINES = 4,
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lreq_valid,
  output logic          lreq_ready,
  input  logic [1:0]    lreq_op,
  input  logic [LW-1:0] lreq_line,
  output logic [1:0]    lreq_outcome,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [LW-1:0] snp_line,
  output logic          snp_retry,
  output logic          snp_shared,
  output logic          bo_valid,
  input  logic          bo_ready,
  output logic [1:0]    bo_cmd,
  output logic [LW-1:0] bo_line,
  input  logic          bus_done,
  input  logic          bus_shared,
  input  logic          bus_retry
);

  logic [LINES-1:0][1:0] line_st;
  logic                  snp_pend, snp_pend_inv, pend_clr;
  logic [LW-1:0]         snp_pend_line;
  logic                  snp_upd_en;
  logic [1:0]            snp_upd_st;
  logic                  busy;
  logic [LW-1:0]         busy_line;
  logic                  done_en;
  logic [LW-1:0]         done_line;
  logic [1:0]            done_st;

  logic [1:0] l_st, loc_cmd, loc_st;
  logic       hit_ok, stall, loc_go, loc_en;

  always_comb begin
    l_st = line_st[lreq_line];
    unique case (lreq_op)
      OP_RD:   hit_ok = l_st != LS_I;
      OP_WR:   hit_ok = l_st == LS_E || l_st == LS_M;
      default: hit_ok = l_st != LS_M;
    endcase

    unique case (lreq_op)
      OP_RD:   loc_cmd = BC_RD;
      OP_WR:   loc_cmd = (l_st == LS_S) ? BC_UPGR : BC_RDX;
      default: loc_cmd = BC_WB;
    endcase

    stall = (snp_valid && snp_line == lreq_line) ||
            (snp_pend && snp_pend_line == lreq_line);

    if (stall)                                          lreq_outcome = OUT_STALL;
    else if (hit_ok && !(busy && busy_line == lreq_line)) lreq_outcome = OUT_HIT;
    else                                                lreq_outcome = OUT_MISS;

    lreq_ready = lreq_valid && lreq_outcome == OUT_HIT;
    loc_go     = lreq_valid && !stall && !hit_ok;

    loc_en = 1'b0;
    loc_st = LS_M;
    if (lreq_ready && lreq_op == OP_WR && l_st == LS_E) begin
      loc_en = 1'b1;
      loc_st = LS_M;
    end else if (lreq_ready && lreq_op == OP_DROP && l_st != LS_I) begin
      loc_en = 1'b1;
      loc_st = LS_I;
    end
  end

  mesi_lc_store #(.LINES(LINES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en   (done_en),
    .bus_line (done_line),
    .bus_st   (done_st),
    .snp_en   (snp_upd_en),
    .snp_line (snp_line),
    .snp_st   (snp_upd_st),
    .loc_en   (loc_en),
    .loc_line (lreq_line),
    .loc_st   (loc_st),
    .st_q     (line_st)
  );

  mesi_lc_snoop #(.LINES(LINES)) u_snoop (
    .clk        (clk),
    .rst_n      (rst_n),
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .snp_line   (snp_line),
    .snp_st     (line_st[snp_line]),
    .wb_clr     (pend_clr),
    .snp_retry  (snp_retry),
    .snp_shared (snp_shared),
    .upd_en     (snp_upd_en),
    .upd_st     (snp_upd_st),
    .pend       (snp_pend),
    .pend_line  (snp_pend_line),
    .pend_inv   (snp_pend_inv)
  );

  mesi_lc_busseq #(.LINES(LINES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend       (snp_pend),
    .pend_line  (snp_pend_line),
    .pend_inv   (snp_pend_inv),
    .loc_go     (loc_go),
    .loc_cmd    (loc_cmd),
    .loc_line   (lreq_line),
    .st         (line_st),
    .bo_ready   (bo_ready),
    .bus_done   (bus_done),
    .bus_shared (bus_shared),
    .bus_retry  (bus_retry),
    .bo_valid   (bo_valid),
    .bo_cmd     (bo_cmd),
    .bo_line    (bo_line),
    .busy       (busy),
    .busy_line  (busy_line),
    .done_en    (done_en),
    .done_line  (done_line),
    .done_st    (done_st),
    .pend_clr   (pend_clr)
  );

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk
  import mesi_lc_pkg::*;
#(
  parameter int LINES = 4,
  localparam int LW = $clog2(LINES)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  lreq_valid,
  input logic                  lreq_ready,
  input logic [1:0]            lreq_op,
  input logic [LW-1:0]         lreq_line,
  input logic                  snp_valid,
  input logic [1:0]            snp_cmd,
  input logic [LW-1:0]         snp_line,
  input logic                  snp_retry,
  input logic                  snp_shared,
  input logic                  bo_valid,
  input logic                  bo_ready,
  input logic [1:0]            bo_cmd,
  input logic [LW-1:0]         bo_line,
  input logic [LINES-1:0][1:0] line_st,
  input logic                  snp_pend,
  input logic [LW-1:0]         snp_pend_line
);

  logic          wr_q, inv_q;
  logic [LW-1:0] wr_line_q, inv_line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q       <= 1'b0;
      inv_q      <= 1'b0;
      wr_line_q  <= '0;
      inv_line_q <= '0;
    end else begin
      wr_q       <= lreq_ready && lreq_op == OP_WR;
      wr_line_q  <= lreq_line;
      inv_q      <= snp_valid && (snp_cmd == BC_RDX || snp_cmd == BC_UPGR) &&
                    (line_st[snp_line] == LS_S || line_st[snp_line] == LS_E);
      inv_line_q <= snp_line;
    end
  end

  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bo_valid && !bo_ready |=> bo_valid && $stable(bo_cmd) && $stable(bo_line));

  a_r4_write_sets_m: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> line_st[wr_line_q] == LS_M);

  a_r6_pend_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    snp_pend |-> line_st[snp_pend_line] == LS_M);

  a_r6_retry_not_shared: assert property (@(posedge clk) disable iff (!rst_n)
    snp_retry |-> !snp_shared);

  a_r10_snoop_blocks_local: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && lreq_valid && snp_line == lreq_line |-> !lreq_ready);

  a_r7_inval_hit: assert property (@(posedge clk) disable iff (!rst_n)
    inv_q |-> line_st[inv_line_q] == LS_I);

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.LINES(LINES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lreq_valid    (lreq_valid),
  .lreq_ready    (lreq_ready),
  .lreq_op       (lreq_op),
  .lreq_line     (lreq_line),
  .snp_valid     (snp_valid),
  .snp_cmd       (snp_cmd),
  .snp_line      (snp_line),
  .snp_retry     (snp_retry),
  .snp_shared    (snp_shared),
  .bo_valid      (bo_valid),
  .bo_ready      (bo_ready),
  .bo_cmd        (bo_cmd),
  .bo_line       (bo_line),
  .line_st       (line_st),
  .snp_pend      (snp_pend),
  .snp_pend_line (snp_pend_line)
);

// File: tb/tb_mesi_line_ctrl.sv
module tb_mesi_line_ctrl;

  localparam int CLK_P = 10;
  localparam int LINES = 4;
  localparam int LW    = $clog2(LINES);
  localparam int LAT   = 2;

  localparam logic [1:0] RD = 2'd0, RDX = 2'd1, UPG = 2'd2, WB = 2'd3;
  localparam logic [1:0] O_RD = 2'd0, O_WR = 2'd1, O_CLN = 2'd2, O_DRP = 2'd3;
  localparam logic [1:0] HIT = 2'd0, MISS = 2'd1, STALL = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lreq_valid = 1'b0, lreq_ready;
  logic [1:0] lreq_op = '0, lreq_outcome;
  logic [LW-1:0] lreq_line = '0;
  logic snp_valid = 1'b0, snp_retry, snp_shared;
  logic [1:0] snp_cmd = '0;
  logic [LW-1:0] snp_line = '0;
  logic bo_valid, bo_ready = 1'b1;
  logic [1:0] bo_cmd;
  logic [LW-1:0] bo_line;
  logic bus_done = 1'b0, bus_shared = 1'b0, bus_retry = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mesi_line_ctrl #(.LINES(LINES)) dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int lat_cnt = 0;
  bit stub_shared = 0, stub_retry = 0;

  typedef struct packed { logic [1:0] cmd; logic [LW-1:0] line; } bxn_t;
  bxn_t exp_q[$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic expect_bus(input logic [1:0] cmd, input int line);
    bxn_t b;
    b.cmd = cmd;
    b.line = LW'(line);
    exp_q.push_back(b);
  endtask

  // monitor: compares every accepted bus transaction against the queue (R11)
  initial forever begin
    @(negedge clk);
    #(CLK_P/2-1);
    if (rst_n && bo_valid && bo_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R11", "unexpected bus cmd", bo_cmd, -1);
      end else begin
        bxn_t e;
        e = exp_q.pop_front();
        chk(bo_cmd == e.cmd, "R11", "bus cmd", bo_cmd, e.cmd);
        chk(bo_line == e.line, "R11", "bus line", bo_line, e.line);
      end
      lat_cnt = LAT;
    end
  end

  // memory stub
  initial forever begin
    @(negedge clk);
    bus_done = 1'b0;
    bus_retry = 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin
        if (stub_retry) begin
          bus_retry = 1'b1;
          stub_retry = 0;
        end else begin
          bus_done = 1'b1;
          bus_shared = stub_shared;
        end
      end
    end
  end

  task automatic local_op(input logic [1:0] op, input int line,
                          input logic [1:0] exp_out, input string rq);
    @(negedge clk);
    lreq_valid = 1'b1;
    lreq_op = op;
    lreq_line = LW'(line);
    #(CLK_P/2-1);
    chk(lreq_outcome == exp_out, rq, "first outcome", lreq_outcome, exp_out);
    for (int i = 0; i < 40 && !lreq_ready; i++) begin
      @(negedge clk);
      #(CLK_P/2-1);
    end
    chk(lreq_ready, rq, "completion", lreq_ready, 1);
    @(negedge clk);
    lreq_valid = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] cmd, input int line,
                       input bit exp_retry, input bit exp_shared, input string rq);
    @(negedge clk);
    snp_valid = 1'b1;
    snp_cmd = cmd;
    snp_line = LW'(line);
    #(CLK_P/2-1);
    chk(snp_retry == exp_retry, rq, "snp_retry", snp_retry, exp_retry);
    chk(snp_shared == exp_shared, rq, "snp_shared", snp_shared, exp_shared);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic drain(input string rq);
    for (int i = 0; i < 60 && (exp_q.size() != 0 || lat_cnt != 0 || bo_valid); i++)
      @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, rq, "pending bus items", exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_P*20000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #(CLK_P/2-1);
    // R1: idle outputs after reset
    chk(bo_valid == 0, "R1", "bo_valid", bo_valid, 0);
    chk(lreq_ready == 0, "R1", "lreq_ready", lreq_ready, 0);
    chk(snp_retry == 0, "R1", "snp_retry", snp_retry, 0);

    // R1/R3: first read misses, no sharer -> Exclusive
    expect_bus(RD, 0);
    local_op(O_RD, 0, MISS, "R1");
    local_op(O_RD, 0, HIT, "R2");
    // R4: write to Exclusive completes locally
    local_op(O_WR, 0, HIT, "R4");
    drain("R4");

    // R6: snooped read of Modified -> retry, writeback, Shared
    expect_bus(WB, 0);
    snoop(RD, 0, 1, 0, "R6");
    drain("R6");
    snoop(RD, 0, 0, 1, "R6");
    expect_bus(UPG, 0);
    local_op(O_WR, 0, MISS, "R5");

    // R6: snooped read-for-ownership of Modified -> writeback, Invalid
    expect_bus(WB, 0);
    snoop(RDX, 0, 1, 0, "R6");
    drain("R6");
    snoop(RD, 0, 0, 0, "R12");
    stub_shared = 1;
    expect_bus(RD, 0);
    local_op(O_RD, 0, MISS, "R3");
    stub_shared = 0;
    expect_bus(UPG, 0);
    local_op(O_WR, 0, MISS, "R5");
    // R5: write to Invalid -> read-for-ownership
    expect_bus(RDX, 1);
    local_op(O_WR, 1, MISS, "R5");

    // R8: clean
    expect_bus(WB, 1);
    local_op(O_CLN, 1, MISS, "R8");
    local_op(O_WR, 1, HIT, "R8");
    local_op(O_CLN, 2, HIT, "R8");
    drain("R8");

    // R9: drop
    expect_bus(WB, 1);
    local_op(O_DRP, 1, MISS, "R9");
    expect_bus(RD, 1);
    local_op(O_RD, 1, MISS, "R9");
    local_op(O_DRP, 1, HIT, "R9");
    expect_bus(RD, 1);
    local_op(O_RD, 1, MISS, "R9");
    drain("R9");

    // R7: snoops on clean lines
    snoop(RD, 1, 0, 1, "R7");
    expect_bus(UPG, 1);
    local_op(O_WR, 1, MISS, "R7");
    stub_shared = 1;
    expect_bus(RD, 2);
    local_op(O_RD, 2, MISS, "R7");
    stub_shared = 0;
    snoop(UPG, 2, 0, 0, "R7");
    expect_bus(RD, 2);
    local_op(O_RD, 2, MISS, "R7");
    drain("R7");

    // R10: snoop and local request on the same line in one cycle
    expect_bus(RD, 3);
    local_op(O_RD, 3, MISS, "R10");
    @(negedge clk);
    lreq_valid = 1'b1;
    lreq_op = O_WR;
    lreq_line = LW'(3);
    snp_valid = 1'b1;
    snp_cmd = RD;
    snp_line = LW'(3);
    #(CLK_P/2-1);
    chk(lreq_outcome == STALL, "R10", "outcome", lreq_outcome, STALL);
    chk(lreq_ready == 0, "R10", "lreq_ready", lreq_ready, 0);
    chk(snp_shared == 1, "R10", "snp_shared", snp_shared, 1);
    expect_bus(UPG, 3);
    @(negedge clk);
    snp_valid = 1'b0;
    #(CLK_P/2-1);
    chk(lreq_outcome == MISS, "R10", "re-evaluated outcome", lreq_outcome, MISS);
    for (int i = 0; i < 40 && !lreq_ready; i++) begin
      @(negedge clk);
      #(CLK_P/2-1);
    end
    chk(lreq_ready, "R10", "completion", lreq_ready, 1);
    @(negedge clk);
    lreq_valid = 1'b0;
    expect_bus(WB, 3);
    snoop(RD, 3, 1, 0, "R10");
    drain("R10");

    // R11: held grant and bus retry
    snoop(RDX, 2, 0, 0, "R7");
    bo_ready = 1'b0;
    stub_retry = 1;
    expect_bus(RD, 2);
    expect_bus(RD, 2);
    @(negedge clk);
    lreq_valid = 1'b1;
    lreq_op = O_RD;
    lreq_line = LW'(2);
    repeat (4) @(negedge clk);
    #(CLK_P/2-1);
    chk(bo_valid == 1, "R11", "bo_valid held", bo_valid, 1);
    chk(bo_cmd == RD && bo_line == LW'(2), "R11", "held cmd/line", {bo_cmd, bo_line}, {RD, LW'(2)});
    @(negedge clk);
    bo_ready = 1'b1;
    for (int i = 0; i < 40 && !lreq_ready; i++) begin
      @(negedge clk);
      #(CLK_P/2-1);
    end
    chk(lreq_ready, "R11", "completion after retry", lreq_ready, 1);
    @(negedge clk);
    lreq_valid = 1'b0;
    drain("R11");

    // R12: snooped writeback ignored on a Modified line
    snoop(WB, 1, 0, 0, "R12");
    local_op(O_WR, 1, HIT, "R12");
    drain("R12");

    finished = 1;
    summary();
    $finish;
  end

endmodule